// File: doc/BRIEF.md
# Processor Bus Address Decoder with ROM Wait State

This block sits beside an 8-bit-data microprocessor whose bus carries a 20-bit memory address or a 16-bit I/O port number. A memory/I-O qualifier tells the two apart. The block turns the address, the qualifier and the active-low read and write lines into three active-low device selects and four active-low command strobes. The selects cover a 32 KB boot ROM at the top of memory, a 512 KB SRAM at the bottom, and a four-register parallel peripheral in I/O space. A device is selected only while a read or write is in progress and the address falls in its window. The low two address bits are passed to the peripheral as its register index.

The boot ROM is slower than one bus period allows. On every ROM read the block pulls the processor's ready line low for one clock after the read is first seen, so the processor inserts a wait state. Ready then stays high until the strobe is removed. SRAM and I/O cycles run without wait states. The span, base addresses and wait length are parameters. The defaults give the map described below.

Top module: `bus_decode_top`

## Requirements
- R1: `rom_cs_n` is low exactly when `io_m` is 0 (memory cycle), the address is in F8000H..FFFFFH, reset is not in force, and `rd_n` or `wr_n` is low.
- R2: `sram_cs_n` is low exactly when `io_m` is 0, the address is in 00000H..7FFFFH, reset is not in force, and `rd_n` or `wr_n` is low.
- R3: `ppi_cs_n` is low exactly when `io_m` is 1 (I/O cycle), `addr[15:0]` is in 0060H..0063H, reset is not in force, and `rd_n` or `wr_n` is low. `addr[19:16]` has no effect in I/O cycles. `ppi_reg` always equals `addr[1:0]`.
- R4: No select is low for memory addresses 80000H..F7FFFH, for any other I/O port, or while `rd_n` and `wr_n` are both high.
- R5: Outside reset, `mem_rd_n` = NOT(!io_m AND !rd_n), `mem_wr_n` = NOT(!io_m AND !wr_n), `io_rd_n` = NOT(io_m AND !rd_n), `io_wr_n` = NOT(io_m AND !wr_n).
- R6: A ROM read (`rom_cs_n` and `mem_rd_n` both low) that is present at a rising edge, with no ROM read at the edge before it, drives `ready` low for exactly one clock period starting at that edge. `ready` then stays high while the same read is held.
- R7: ROM writes, SRAM cycles, I/O cycles and idle bus never pull `ready` low.
- R8: While `rst_n` is low, all selects and strobes are high and `ready` is high. This holds asynchronously, including in the middle of a wait state. Decoding resumes only after the first rising edge seen with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| addr | input | 20 | Memory address, or I/O port in bits 15:0 |
| io_m | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read request |
| wr_n | input | 1 | Active-low write request |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| sram_cs_n | output | 1 | SRAM select, active low |
| ppi_cs_n | output | 1 | Parallel peripheral select, active low |
| ppi_reg | output | 2 | Peripheral register index |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| ready | output | 1 | Processor ready, low during the ROM wait state |

## Verification
The properties assume that the processor never drives `rd_n` and `wr_n` low together. The one-hot check on the strobes is qualified on that. The stimulus never produces such a cycle: each transaction picks a read, a write or idle, never both. The stimulus also changes the inputs only on the falling clock edge, so the ready timing is judged against stable bus values at each rising edge. Addresses are drawn by region, including the window edges, so every select boundary is exercised.

// File: rtl/bus_decode_pkg.sv
package bus_decode_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_WAIT = 2'd1,
    WS_HOLD = 2'd2
  } ws_state_e;

endpackage

// File: rtl/bus_region_decode.sv
module bus_region_decode #(
  parameter int ADDR_W    = 20,
  parameter int PORT_W    = 16,
  parameter int ROM_LOG2  = 15,
  parameter int SRAM_LOG2 = 19,
  parameter int PPI_LOG2  = 2,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 20'hF8000,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 20'h00000,
  parameter logic [PORT_W-1:0] PPI_BASE  = 16'h0060
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_m,
  output logic              rom_hit,
  output logic              sram_hit,
  output logic              ppi_hit
);

  localparam int ROM_TAG_W  = ADDR_W - ROM_LOG2;
  localparam int SRAM_TAG_W = ADDR_W - SRAM_LOG2;
  localparam int PPI_TAG_W  = PORT_W - PPI_LOG2;

  logic [ROM_TAG_W-1:0]  rom_tag;
  logic [SRAM_TAG_W-1:0] sram_tag;
  logic [PPI_TAG_W-1:0]  ppi_tag;

  always_comb begin
    rom_tag  = addr[ADDR_W-1:ROM_LOG2];
    sram_tag = addr[ADDR_W-1:SRAM_LOG2];
    ppi_tag  = addr[PORT_W-1:PPI_LOG2];
    rom_hit  = !io_m && (rom_tag  == ROM_BASE[ADDR_W-1:ROM_LOG2]);
    sram_hit = !io_m && (sram_tag == SRAM_BASE[ADDR_W-1:SRAM_LOG2]);
    ppi_hit  =  io_m && (ppi_tag  == PPI_BASE[PORT_W-1:PPI_LOG2]);
  end

endmodule

// File: rtl/bus_cmd_strobe.sv
module bus_cmd_strobe (
  input  logic run,
  input  logic io_m,
  input  logic rd_n,
  input  logic wr_n,
  output logic mem_rd_n,
  output logic mem_wr_n,
  output logic io_rd_n,
  output logic io_wr_n,
  output logic cycle_act
);

  logic rd_act;
  logic wr_act;

  always_comb begin
    rd_act    = run && !rd_n;
    wr_act    = run && !wr_n;
    mem_rd_n  = !(rd_act && !io_m);
    mem_wr_n  = !(wr_act && !io_m);
    io_rd_n   = !(rd_act &&  io_m);
    io_wr_n   = !(wr_act &&  io_m);
    cycle_act = rd_act || wr_act;
  end

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bus_decode_pkg::*;
#(
  parameter int WAIT_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_rd,
  output logic ready
);

  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYCLES - 1);

  ws_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (slow_rd) begin
          state_d = WS_WAIT;
          cnt_d   = CNT_LOAD;
          cnt_en  = 1'b1;
        end
      end
      WS_WAIT: begin
        if (!slow_rd) begin
          state_d = WS_IDLE;
        end else if (cnt_q == '0) begin
          state_d = WS_HOLD;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      WS_HOLD: begin
        if (!slow_rd) state_d = WS_IDLE;
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = (state_q != WS_WAIT);

endmodule

// File: rtl/bus_decode_top.sv
module bus_decode_top #(
  parameter int ADDR_W      = 20,
  parameter int PORT_W      = 16,
  parameter int ROM_LOG2    = 15,
  parameter int SRAM_LOG2   = 19,
  parameter int PPI_LOG2    = 2,
  parameter int WAIT_CYCLES = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                io_m,
  input  logic                rd_n,
  input  logic                wr_n,
  output logic                rom_cs_n,
  output logic                sram_cs_n,
  output logic                ppi_cs_n,
  output logic [PPI_LOG2-1:0] ppi_reg,
  output logic                mem_rd_n,
  output logic                mem_wr_n,
  output logic                io_rd_n,
  output logic                io_wr_n,
  output logic                ready
);

  logic run_q;
  logic rom_hit, sram_hit, ppi_hit;
  logic cycle_act;
  logic slow_rd;

  // Reset is applied at once and released on the next clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
    end
  end

  bus_region_decode #(
    .ADDR_W    (ADDR_W),
    .PORT_W    (PORT_W),
    .ROM_LOG2  (ROM_LOG2),
    .SRAM_LOG2 (SRAM_LOG2),
    .PPI_LOG2  (PPI_LOG2)
  ) region_i (
    .addr     (addr),
    .io_m     (io_m),
    .rom_hit  (rom_hit),
    .sram_hit (sram_hit),
    .ppi_hit  (ppi_hit)
  );

  bus_cmd_strobe strobe_i (
    .run       (run_q),
    .io_m      (io_m),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n),
    .cycle_act (cycle_act)
  );

  always_comb begin
    rom_cs_n  = !(rom_hit  && cycle_act);
    sram_cs_n = !(sram_hit && cycle_act);
    ppi_cs_n  = !(ppi_hit  && cycle_act);
    ppi_reg   = addr[PPI_LOG2-1:0];
    slow_rd   = !rom_cs_n && !mem_rd_n;
  end

  bus_wait_gen #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) wait_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .slow_rd (slow_rd),
    .ready   (ready)
  );

endmodule

// File: rtl/bus_decode_chk.sv
module bus_decode_chk #(
  parameter int WAIT_CYCLES = 1
) (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic wr_n,
  input logic rom_cs_n,
  input logic sram_cs_n,
  input logic ppi_cs_n,
  input logic mem_rd_n,
  input logic mem_wr_n,
  input logic io_rd_n,
  input logic io_wr_n,
  input logic ready
);

  localparam int LW = $clog2(WAIT_CYCLES + 2);

  logic          rom_rd_w;
  logic [LW-1:0] low_len;

  assign rom_rd_w = !rom_cs_n && !mem_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len <= '0;
    end else if (!ready) begin
      if (low_len != LW'(WAIT_CYCLES + 1)) low_len <= low_len + 1'b1;
    end else begin
      low_len <= '0;
    end
  end

  assert_sel_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rom_cs_n, !sram_cs_n, !ppi_cs_n}) <= 1);

  assert_no_sel_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> (rom_cs_n && sram_cs_n && ppi_cs_n));

  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n) |-> $onehot0({!mem_rd_n, !mem_wr_n, !io_rd_n, !io_wr_n}));

  assert_wait_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rom_rd_w) && ready) |=> !ready);

  assert_wait_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_len <= LW'(WAIT_CYCLES));

  assert_wait_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(rom_rd_w));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n |-> (rom_cs_n && sram_cs_n && ppi_cs_n && mem_rd_n && mem_wr_n
                && io_rd_n && io_wr_n && ready));

endmodule

bind bus_decode_top bus_decode_chk #(.WAIT_CYCLES(WAIT_CYCLES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .rom_cs_n  (rom_cs_n),
  .sram_cs_n (sram_cs_n),
  .ppi_cs_n  (ppi_cs_n),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .io_rd_n   (io_rd_n),
  .io_wr_n   (io_wr_n),
  .ready     (ready)
);

// File: tb/bus_decode_top_tb_top.sv
module bus_decode_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [19:0] addr;
  logic        io_m;
  logic        rd_n;
  logic        wr_n;
  logic        rom_cs_n, sram_cs_n, ppi_cs_n;
  logic [1:0]  ppi_reg;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic        ready;

  int n_tests;
  int n_fail;
  bit exp_run;
  int k_edges;
  bit exp_rom_rd;
  bit done;

  bus_decode_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .io_m      (io_m),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rom_cs_n  (rom_cs_n),
    .sram_cs_n (sram_cs_n),
    .ppi_cs_n  (ppi_cs_n),
    .ppi_reg   (ppi_reg),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n),
    .ready     (ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit in_rom(input logic [19:0] a, input logic io);
    return !io && a >= 20'hF8000;
  endfunction
  function automatic bit in_sram(input logic [19:0] a, input logic io);
    return !io && a <= 20'h7FFFF;
  endfunction
  function automatic bit in_ppi(input logic [19:0] a, input logic io);
    return io && a[15:0] >= 16'h0060 && a[15:0] <= 16'h0063;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (addr=%h io_m=%b rd_n=%b wr_n=%b)",
               tag, act, exp, addr, io_m, rd_n, wr_n);
    end
  endtask

  // Inputs are already applied at the falling edge; check, then cross one rising edge.
  task automatic step();
    bit cyc;
    if (!rst_n) begin exp_run = 0; k_edges = 0; end
    #5;
    cyc = exp_run && (!rd_n || !wr_n);
    chk(exp_run ? (in_rom(addr, io_m) ? "R1" : "R4") : "R8", rom_cs_n,
        !(cyc && in_rom(addr, io_m)));
    chk(exp_run ? (in_sram(addr, io_m) ? "R2" : "R4") : "R8", sram_cs_n,
        !(cyc && in_sram(addr, io_m)));
    chk(exp_run ? (in_ppi(addr, io_m) ? "R3" : "R4") : "R8", ppi_cs_n,
        !(cyc && in_ppi(addr, io_m)));
    chk("R3", ppi_reg[0], addr[0]);
    chk("R3", ppi_reg[1], addr[1]);
    chk(exp_run ? "R5" : "R8", mem_rd_n, !(exp_run && !io_m && !rd_n));
    chk(exp_run ? "R5" : "R8", mem_wr_n, !(exp_run && !io_m && !wr_n));
    chk(exp_run ? "R5" : "R8", io_rd_n,  !(exp_run &&  io_m && !rd_n));
    chk(exp_run ? "R5" : "R8", io_wr_n,  !(exp_run &&  io_m && !wr_n));
    exp_rom_rd = exp_run && !rd_n && in_rom(addr, io_m);
    @(posedge clk);
    if (rst_n) begin
      k_edges = exp_rom_rd ? ((k_edges < 3) ? k_edges + 1 : k_edges) : 0;
      exp_run = 1;
    end
    #2;
    chk((k_edges == 1) ? "R6" : (exp_rom_rd ? "R6" : "R7"), ready, (k_edges != 1));
    @(negedge clk);
  endtask

  task automatic drive(input logic [19:0] a, input logic io, input logic r, input logic w);
    addr = a; io_m = io; rd_n = r; wr_n = w;
  endtask

  function automatic logic [19:0] pick_addr(input int region);
    logic [19:0] r;
    r = 20'($urandom);
    case (region)
      0: return {1'b0, r[18:0]};
      1: return {5'b11111, r[14:0]};
      2: return 20'h80000 + 20'(r % 20'h78000);
      3: return {r[19:2], 2'b00} | 20'h00060 & 20'hFFF63 | {16'h0, 2'b0, r[1:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    n_tests = 0; n_fail = 0; exp_run = 0; k_edges = 0; done = 0;
    rst_n = 0;
    drive(20'hFFFF0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    // R8: quiet during reset even with a ROM read present
    step(); step();
    rst_n = 1;
    step(); step(); step();   // R6: wait state once decoding resumes
    drive(20'h00000, 1'b0, 1'b1, 1'b1); step();
    // Window edges: R1, R2, R4
    drive(20'h7FFFF, 1'b0, 1'b1, 1'b0); step();
    drive(20'h80000, 1'b0, 1'b0, 1'b1); step();
    drive(20'hF7FFF, 1'b0, 1'b0, 1'b1); step();
    drive(20'hF8000, 1'b0, 1'b1, 1'b0); step(); step(); // R7: ROM write, no wait
    drive(20'hFFFFF, 1'b0, 1'b0, 1'b1); step(); step();
    drive(20'hF8000, 1'b0, 1'b0, 1'b1); step();         // same read held: R6
    // I/O edges: R3, R4
    drive(20'hA005F, 1'b1, 1'b0, 1'b1); step();
    drive(20'hA0060, 1'b1, 1'b0, 1'b1); step();
    drive(20'h50063, 1'b1, 1'b1, 1'b0); step();
    drive(20'h00064, 1'b1, 1'b1, 1'b0); step();
    drive(20'hFFFF0, 1'b1, 1'b0, 1'b1); step();         // I/O at ROM-like address
    // R8: reset in the middle of a wait state
    drive(20'hFC000, 1'b0, 1'b1, 1'b1); step();
    drive(20'hFC000, 1'b0, 1'b0, 1'b1); @(posedge clk); @(negedge clk);
    rst_n = 0; step();
    rst_n = 1; step(); step(); step();
    // Constrained random transactions
    void'($urandom(32'h5EED_0042));
    for (int t = 0; t < 1500; t++) begin
      int region, kind, hold;
      logic [19:0] a;
      logic io;
      region = int'($urandom % 5);
      a = pick_addr(region);
      io = (region == 3) ? 1'b1 : (region == 4) ? 1'($urandom) : 1'b0;
      kind = int'($urandom % 3);
      hold = 1 + int'($urandom % 4);
      drive(a, io, kind != 0, kind != 1);
      for (int h = 0; h < hold; h++) step();
      if ($urandom % 3 == 0) begin
        drive(a, io, 1'b1, 1'b1);
        step();
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule